// File: doc/BRIEF.md
# Ternary Content-Addressable Memory with Shared Bit Mask

This block is a synchronous ternary lookup table. Software or upstream logic fills its entries through a RAM-style write port: an address, a data word, a write strobe and a chip select. It then presents search words on the same data bus. Each entry holds a value and a per-bit care vector, so a stored bit can be 0, 1 or "either". Every search is checked against all entries in parallel. The block reports whether anything matched, the lowest matching entry index, and whether two or more entries matched.

One global mask register is loaded from the data bus by its own strobe. A separate, unregistered enable-mask input arms it. While armed, the masked bit positions are protected during writes and excluded from searches. A write-don't-care input turns a write into one that clears the care bits of the unmasked positions, so those positions then match either search value. A parameter selects whether the result outputs are registered or combinational.

Top module: `tcam_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) invalidates every entry, clears the mask register and drives hit, multi_hit and match_addr to 0. After reset no search word matches, including the all-zero word.
- R2: At a clock edge with ce, we and wcs all high, the entry at waddr is marked valid and takes wdata in every unprotected bit position, with those bits becoming cared. If we or wcs is low, no entry changes.
- R3: At every clock edge with ce high, wdata is captured as the search word. An entry matches when it is valid and every cared, unmasked bit equals the search word. hit is 1 and match_addr is the lowest matching index.
- R4: multi_hit is 1 only when two or more entries match the search word, and multi_hit is never 1 without hit.
- R5: When no entry matches, hit, multi_hit and match_addr are all 0.
- R6: During a write with en_mask high, every bit position holding 1 in the mask register keeps its stored value and care state.
- R7: During a search with en_mask high, bit positions holding 1 in the mask register count as matching whatever their stored or searched value.
- R8: A write with wr_dc high clears the care bit of each unprotected position and marks the entry valid, so those positions match both 0 and 1. Positions protected by the mask keep their previous value and care state.
- R9: At a clock edge with ce and wr_mask high, the mask register loads wdata. While en_mask is low, the mask register has no effect on writes or searches.
- R10: While ce is low, no entry, mask or search word is captured and the registered outputs hold their values.
- R11: With REG_OUT=1, results appear one clock edge after the search word is captured. With REG_OUT=0, they appear right after the capturing edge, one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all captured inputs and outputs |
| wdata | input | WIDTH | Write data, search word and mask load value |
| waddr | input | AW | Entry index for writes |
| we | input | 1 | Write enable |
| wcs | input | 1 | Write chip select |
| wr_dc | input | 1 | Store don't-care states instead of data |
| wr_mask | input | 1 | Load the mask register from wdata |
| en_mask | input | 1 | Arms the mask register (not registered) |
| match_addr | output | AW | Lowest matching entry index, 0 when none |
| hit | output | 1 | At least one entry matches |
| multi_hit | output | 1 | Two or more entries match |

## Verification
Several properties are checked on every cycle: a miss forces all outputs to zero, multi_hit implies hit, no result survives the cycle after reset, and registered outputs hold while ce is low. Other behaviour can only be shown by the bench's scenarios: the exact index chosen among several hits, partial writes under the mask, don't-care entries matching either polarity, and the ignored-bit search. These depend on what the table holds, so the bench checks them against values worked out by hand from a known sequence of writes. The one-cycle latency difference between the two output variants is shown by running a second instance side by side.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_DATA = 2'd1,
    WK_DONT = 2'd2
  } wr_kind_e;

  function automatic wr_kind_e decode_write(input logic ce, input logic we,
                                            input logic cs, input logic dc);
    if (!(ce && we && cs)) return WK_NONE;
    return dc ? WK_DONT : WK_DATA;
  endfunction

endpackage

// File: rtl/tcam_mask_reg.sv
module tcam_mask_reg #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             arm,
  output logic [WIDTH-1:0] mask_eff
);

  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (ce && load) begin
      mask_q <= din;
    end
  end

  // the arm input is live, not registered
  assign mask_eff = arm ? mask_q : '0;

endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int WIDTH   = 48,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  wr_kind_e           wkind,
  input  logic [AW-1:0]      waddr,
  input  logic [WIDTH-1:0]   wdata,
  input  logic [WIDTH-1:0]   keep,
  input  logic [WIDTH-1:0]   key,
  output logic [ENTRIES-1:0] hits
);

  logic [WIDTH-1:0]   val_q  [ENTRIES];
  logic [WIDTH-1:0]   care_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic               addr_ok;

  assign addr_ok = (32'(waddr) < ENTRIES);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        val_q[e]  <= '0;
        care_q[e] <= '1;
      end
      vld_q <= '0;
    end else if (addr_ok) begin
      unique case (wkind)
        WK_DATA: begin
          val_q[waddr]  <= (val_q[waddr] & keep) | (wdata & ~keep);
          care_q[waddr] <= care_q[waddr] | ~keep;
          vld_q[waddr]  <= 1'b1;
        end
        WK_DONT: begin
          val_q[waddr]  <= val_q[waddr] & keep;
          care_q[waddr] <= care_q[waddr] & keep;
          vld_q[waddr]  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // one comparator per entry; masked positions (keep) always agree
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [WIDTH-1:0] bit_ok;
    assign bit_ok  = ~care_q[e] | keep | ~(val_q[e] ^ key);
    assign hits[e] = vld_q[e] & (&bit_ok);
  end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int ENTRIES = 128,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hits,
  output logic [AW-1:0]      idx,
  output logic               any,
  output logic               many
);

  always_comb begin
    idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hits[e]) idx = AW'(e);
    end
  end

  assign any  = |hits;
  // clearing the lowest set bit leaves something iff two or more are set
  assign many = |(hits & (hits - ENTRIES'(1)));

endmodule

// File: rtl/tcam_top.sv
module tcam_top
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int WIDTH   = 48,
  parameter bit REG_OUT = 1'b1,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    waddr,
  input  logic             we,
  input  logic             wcs,
  input  logic             wr_dc,
  input  logic             wr_mask,
  input  logic             en_mask,
  output logic [AW-1:0]    match_addr,
  output logic             hit,
  output logic             multi_hit
);

  logic [WIDTH-1:0]   mask_eff;
  logic [WIDTH-1:0]   key_q;
  logic [ENTRIES-1:0] hits;
  logic [AW-1:0]      enc_idx;
  logic               enc_any;
  logic               enc_many;
  wr_kind_e           wkind;

  assign wkind = decode_write(ce, we, wcs, wr_dc);

  tcam_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .load     (wr_mask),
    .din      (wdata),
    .arm      (en_mask),
    .mask_eff (mask_eff)
  );

  // search word register
  always_ff @(posedge clk) begin
    if (rst)     key_q <= '0;
    else if (ce) key_q <= wdata;
  end

  tcam_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_array (
    .clk   (clk),
    .rst   (rst),
    .wkind (wkind),
    .waddr (waddr),
    .wdata (wdata),
    .keep  (mask_eff),
    .key   (key_q),
    .hits  (hits)
  );

  tcam_prio_enc #(.ENTRIES(ENTRIES)) u_enc (
    .hits (hits),
    .idx  (enc_idx),
    .any  (enc_any),
    .many (enc_many)
  );

  if (REG_OUT) begin : g_reg_out
    logic [AW-1:0] addr_q;
    logic          hit_q;
    logic          multi_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q  <= '0;
        hit_q   <= 1'b0;
        multi_q <= 1'b0;
      end else if (ce) begin
        addr_q  <= enc_idx;
        hit_q   <= enc_any;
        multi_q <= enc_many;
      end
    end
    assign match_addr = addr_q;
    assign hit        = hit_q;
    assign multi_hit  = multi_q;
  end else begin : g_comb_out
    assign match_addr = enc_idx;
    assign hit        = enc_any;
    assign multi_hit  = enc_many;
  end

endmodule

// File: rtl/tcam_checker.sv
module tcam_checker #(
  parameter int AW      = 7,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic [AW-1:0] match_addr,
  input logic          hit,
  input logic          multi_hit
);

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (match_addr == '0 && !multi_hit));

  assert_multi_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
    multi_hit |-> hit);

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hit && !multi_hit && match_addr == '0));

  if (REG_OUT) begin : g_hold
    assert_ce_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!ce && !rst) |=> ($stable(hit) && $stable(multi_hit) && $stable(match_addr)));
  end

endmodule

bind tcam_top tcam_checker #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce         (ce),
  .match_addr (match_addr),
  .hit        (hit),
  .multi_hit  (multi_hit)
);

// File: tb/tb_tcam_top.sv
`timescale 1ns/1ps
module tb_tcam_top;

  localparam int W  = 48;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b1;
  logic [W-1:0]  wdata = '0;
  logic [AW-1:0] waddr = '0;
  logic          we = 1'b0, wcs = 1'b0, wr_dc = 1'b0, wr_mask = 1'b0, en_mask = 1'b0;
  logic [AW-1:0] addr_r, addr_c;
  logic          hit_r, hit_c, multi_r, multi_c;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcam_top #(.ENTRIES(128), .WIDTH(W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .ce(ce), .wdata(wdata), .waddr(waddr), .we(we),
    .wcs(wcs), .wr_dc(wr_dc), .wr_mask(wr_mask), .en_mask(en_mask),
    .match_addr(addr_r), .hit(hit_r), .multi_hit(multi_r));

  tcam_top #(.ENTRIES(128), .WIDTH(W), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .ce(ce), .wdata(wdata), .waddr(waddr), .we(we),
    .wcs(wcs), .wr_dc(wr_dc), .wr_mask(wr_mask), .en_mask(en_mask),
    .match_addr(addr_c), .hit(hit_c), .multi_hit(multi_c));

  typedef struct packed {
    logic [W-1:0]  key;
    logic          hit;
    logic [AW-1:0] adr;
    logic          multi;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{48'h0000_1111_2222, 1'b1, 7'd5,   1'b1},
    '{48'hABCD_0000_0000, 1'b1, 7'd20,  1'b0},
    '{48'hFFFF_FFFF_FFFF, 1'b1, 7'd127, 1'b0},
    '{48'h1234_5678_9ABC, 1'b0, 7'd0,   1'b0},
    '{48'hABCD_0000_0001, 1'b0, 7'd0,   1'b0},
    '{48'h0000_0000_0000, 1'b0, 7'd0,   1'b0}
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got {hit,addr,multi}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic dc,
                    input logic cs);
    waddr = a; wdata = d; wr_dc = dc; we = 1'b1; wcs = cs;
    @(negedge clk);
    we = 1'b0; wcs = 1'b0; wr_dc = 1'b0;
  endtask

  task automatic load_mask(input logic [W-1:0] m);
    wdata = m; wr_mask = 1'b1;
    @(negedge clk);
    wr_mask = 1'b0;
  endtask

  // search: combinational copy checked after the capturing edge, registered one edge later
  task automatic search(input string req, input logic [W-1:0] k, input logic eh,
                        input logic [AW-1:0] ea, input logic em);
    wdata = k;
    @(negedge clk);
    chk({req, "/R11 comb"}, {hit_c, addr_c, multi_c}, {eh, ea, em});
    @(negedge clk);
    chk(req, {hit_r, addr_r, multi_r}, {eh, ea, em});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    chk("R1 reset outputs", {hit_r, addr_r, multi_r}, 9'd0);
    search("R1 all-zero word misses", '0, 1'b0, 7'd0, 1'b0);

    wr(7'd5,   48'h0000_1111_2222, 1'b0, 1'b1);
    wr(7'd9,   48'h0000_1111_2222, 1'b0, 1'b1);
    wr(7'd20,  48'hABCD_0000_0000, 1'b0, 1'b1);
    wr(7'd127, 48'hFFFF_FFFF_FFFF, 1'b0, 1'b1);

    for (int i = 0; i < 6; i++) begin
      search($sformatf("R2/R3/R4/R5 vector %0d", i), VECS[i].key, VECS[i].hit,
             VECS[i].adr, VECS[i].multi);
    end

    // R10: outputs hold with ce low
    search("R3 top entry", 48'hFFFF_FFFF_FFFF, 1'b1, 7'd127, 1'b0);
    ce = 1'b0; wdata = 48'h1234_5678_9ABC;
    repeat (2) @(negedge clk);
    chk("R10 outputs hold", {hit_r, addr_r, multi_r}, {1'b1, 7'd127, 1'b0});
    wr(7'd3, 48'h5555_5555_5555, 1'b0, 1'b1);
    ce = 1'b1;
    search("R10 write ignored with ce low", 48'h5555_5555_5555, 1'b0, 7'd0, 1'b0);

    // R2: chip select low blocks write
    wr(7'd3, 48'h6666_6666_6666, 1'b0, 1'b0);
    search("R2 write ignored without wcs", 48'h6666_6666_6666, 1'b0, 7'd0, 1'b0);

    // R9/R6: mask load and protected write
    load_mask(48'h0000_0000_FFFF);
    en_mask = 1'b1;
    wr(7'd20, 48'h1111_1111_1111, 1'b0, 1'b1);
    en_mask = 1'b0;
    search("R6 protected bits kept", 48'h1111_1111_0000, 1'b1, 7'd20, 1'b0);

    // R7: masked compare
    en_mask = 1'b1;
    search("R7 masked compare", 48'h1111_1111_BEEF, 1'b1, 7'd20, 1'b0);
    en_mask = 1'b0;
    search("R9 mask inactive when en_mask low", 48'h1111_1111_BEEF, 1'b0, 7'd0, 1'b0);

    // R8: don't-care write limited by mask (low 16 bits stay cared, value 0)
    en_mask = 1'b1;
    wr(7'd0, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b1);
    en_mask = 1'b0;
    search("R8 dont-care upper bits", 48'h1234_5678_0000, 1'b1, 7'd0, 1'b0);
    search("R8 dont-care both polarities", 48'hEDCB_A987_0000, 1'b1, 7'd0, 1'b0);
    search("R8 protected bits still cared", 48'h1234_5678_0001, 1'b0, 7'd0, 1'b0);
    search("R4 lowest of two hits", 48'h1111_1111_0000, 1'b1, 7'd0, 1'b1);

    // R1: reset again empties the table and mask
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    search("R1 table empty after reset", 48'h0000_1111_2222, 1'b0, 7'd0, 1'b0);
    en_mask = 1'b1;
    search("R1 mask cleared by reset", 48'h0000_1111_2222, 1'b0, 7'd0, 1'b0);
    en_mask = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule